// File: doc/BRIEF.md
# SPI FIFO Level, Status and Interrupt Unit

This block sits between the register interface of an SPI controller and its shift engine. It holds a transmit queue, which the register interface fills and the shift engine drains, and a receive queue, which the shift engine fills and the register interface drains. From the two queues it derives occupancy counts, a five-bit status word and a five-bit interrupt set. The interrupt set has a raw view, a masked view and one combined interrupt line.

Two of the interrupt sources follow the queue levels against programmable watermarks. The other three are sticky error flags for overflow and underflow, and software clears them with a clear word. That word can clear the flags one at a time or all together. When the controller enable is low, both queues are held empty, and the watermarks can only be changed in that state. Queue depth must be a power of two.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Each queue returns words in the order they were accepted, and the head word is shown on its pop-data output while the queue is not empty. A level rises by one for each accepted push and falls by one for each accepted pop, one cycle after the strobe. A push and a pop accepted together leave the level unchanged.
- R2: A push to a full queue (level = DEPTH) is dropped and a pop from an empty queue is dropped. In both cases the level and the contents are unchanged.
- R3: Status bit 0 is busy, which is enable AND (shift_active OR transmit level ≠ 0). Bit 1 is transmit full, bit 2 is transmit empty, bit 3 is receive empty and bit 4 is receive full.
- R4: Interrupt bit 0 (transmit watermark) is high while the transmit level is at or below the transmit watermark.
- R5: Interrupt bit 4 (receive watermark) is high while the receive level is greater than the receive watermark, which means from watermark + 1 entries onward.
- R6: Interrupt bit 1 (transmit overflow), bit 2 (receive underflow) and bit 3 (receive overflow) are set in the cycle after the offending strobe. They stay set until they are cleared or the block is reset.
- R7: A clear strobe acts on its clear word as follows: bit 0 clears all three error flags, bit 1 clears receive underflow, bit 2 clears receive overflow and bit 3 clears transmit overflow. An error event in the same cycle as the clear keeps its flag set.
- R8: The masked word equals the raw word AND the mask register. The interrupt line is the OR of the masked bits. A mask of zero holds the line low.
- R9: While enable is low, both levels are zero from the next cycle on. Push and pop strobes are ignored and raise no error flag.
- R10: A watermark write keeps only the low log2(DEPTH) bits of the written value. Watermark writes made while enable is high are ignored.
- R11: After reset, both levels, both watermarks, the mask and all error flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low flushes both queues |
| shift_active | input | 1 | Shift engine is mid-frame |
| tx_push | input | 1 | Register interface writes a transmit word |
| tx_push_data | input | WIDTH | Transmit word |
| tx_pop | input | 1 | Shift engine takes the transmit head |
| tx_pop_data | output | WIDTH | Transmit head word |
| rx_push | input | 1 | Shift engine stores a received word |
| rx_push_data | input | WIDTH | Received word |
| rx_pop | input | 1 | Register interface reads a receive word |
| rx_pop_data | output | WIDTH | Receive head word |
| tx_wm_wr | input | 1 | Transmit watermark write strobe |
| rx_wm_wr | input | 1 | Receive watermark write strobe |
| wm_wdata | input | WM_IN_W | Watermark write value |
| tx_wm | output | WM_W | Transmit watermark readback |
| rx_wm | output | WM_W | Receive watermark readback |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 5 | Mask value |
| clr_wr | input | 1 | Clear strobe |
| clr_wdata | input | 4 | Clear word |
| tx_level | output | LVL_W | Transmit occupancy |
| rx_level | output | LVL_W | Receive occupancy |
| status | output | 5 | Status word |
| irq_raw | output | 5 | Raw interrupt word |
| irq_masked | output | 5 | Masked interrupt word |
| irq | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach from the ports is an error event and a clear of the same flag landing in one cycle, while the queue involved is exactly full or empty. To get there, the stimulus first fills the transmit queue to DEPTH and drains the receive queue. It then issues an overflowing push together with its matching clear. A later long phase of mixed random traffic, with occasional enable drops, clear words and mask writes, is compared on every cycle against a queue-based behavioural model, so that watermark edges and flush interactions come up many times.

// File: rtl/spi_fsi_pkg.sv
package spi_fsi_pkg;

    localparam int IRQ_W = 5;
    localparam int CLR_W = 4;

    // clear word bit positions
    localparam int CLR_ALL    = 0;
    localparam int CLR_RX_UDF = 1;
    localparam int CLR_RX_OVF = 2;
    localparam int CLR_TX_OVF = 3;

    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } fsi_status_t;

    typedef struct packed {
        logic rx_wm;
        logic rx_ovf;
        logic rx_udf;
        logic tx_ovf;
        logic tx_wm;
    } fsi_irq_t;

    typedef struct packed {
        logic rx_ovf;
        logic rx_udf;
        logic tx_ovf;
    } fsi_err_t;

    function automatic fsi_err_t clear_vec(input logic [CLR_W-1:0] w);
        fsi_err_t c;
        c.rx_ovf = w[CLR_ALL] | w[CLR_RX_OVF];
        c.rx_udf = w[CLR_ALL] | w[CLR_RX_UDF];
        c.tx_ovf = w[CLR_ALL] | w[CLR_TX_OVF];
        return c;
    endfunction

endpackage

// File: rtl/spi_fsi_fifo.sv
module spi_fsi_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [LVL_W-1:0] level,
    output logic             ovf_ev,
    output logic             udf_ev
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             is_full, is_empty, push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign is_full  = (level == FULL_LVL);
    assign is_empty = (level == '0);
    assign push_ok  = push && !flush && !is_full;
    assign pop_ok   = pop && !flush && !is_empty;
    assign ovf_ev   = push && !flush && is_full;
    assign udf_ev   = pop && !flush && is_empty;
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    a_r1_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    a_r1_pair_keeps_level: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !flush && level != '0 && level != FULL_LVL) |=> $stable(level));

    a_r2_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && level == FULL_LVL) |=> (level == FULL_LVL));

    a_r2_empty_pop_dropped: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !flush && level == '0) |=> (level == '0));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0));

endmodule

// File: rtl/spi_fsi_wm.sv
module spi_fsi_wm #(
    parameter int DEPTH   = 32,
    parameter int WM_IN_W = 8,
    localparam int WM_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               wr,
    input  logic [WM_IN_W-1:0] wdata,
    output logic [WM_W-1:0]    wm
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wm <= '0;
        end else if (wr && !enable) begin
            wm <= wdata[WM_W-1:0];
        end
    end

    a_r10_locked_when_enabled: assert property (@(posedge clk) disable iff (rst)
        enable |=> $stable(wm));

endmodule

// File: rtl/spi_fsi_irq.sv
module spi_fsi_irq
    import spi_fsi_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int WM_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [WM_W-1:0]  tx_wm,
    input  logic [WM_W-1:0]  rx_wm,
    input  logic             tx_ovf_ev,
    input  logic             rx_ovf_ev,
    input  logic             rx_udf_ev,
    input  logic             mask_wr,
    input  logic [IRQ_W-1:0] mask_wdata,
    input  logic             clr_wr,
    input  logic [CLR_W-1:0] clr_wdata,
    output fsi_irq_t         raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq_o
);

    fsi_err_t         err_q, clr;
    logic [IRQ_W-1:0] mask_q;

    assign clr = clr_wr ? clear_vec(clr_wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= '0;
            mask_q <= '0;
        end else begin
            err_q.tx_ovf <= tx_ovf_ev | (err_q.tx_ovf & ~clr.tx_ovf);
            err_q.rx_ovf <= rx_ovf_ev | (err_q.rx_ovf & ~clr.rx_ovf);
            err_q.rx_udf <= rx_udf_ev | (err_q.rx_udf & ~clr.rx_udf);
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    always_comb begin
        raw.tx_wm  = ({1'b0, tx_level} <= {{(LVL_W - WM_W + 1){1'b0}}, tx_wm});
        raw.rx_wm  = ({1'b0, rx_level} >  {{(LVL_W - WM_W + 1){1'b0}}, rx_wm});
        raw.tx_ovf = err_q.tx_ovf;
        raw.rx_ovf = err_q.rx_ovf;
        raw.rx_udf = err_q.rx_udf;
    end

    assign masked = raw & mask_q;
    assign irq_o  = |masked;

    a_r6_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (raw.rx_ovf && !clr_wr) |=> raw.rx_ovf);

    a_r6_set_on_event: assert property (@(posedge clk) disable iff (rst)
        tx_ovf_ev |=> raw.tx_ovf);

    a_r7_clear_all: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_wdata[CLR_ALL] && !tx_ovf_ev && !rx_ovf_ev && !rx_udf_ev)
        |=> (!raw.tx_ovf && !raw.rx_ovf && !raw.rx_udf));

    a_r8_zero_mask_silent: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && mask_wdata == '0) |=> !irq_o);

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_fsi_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int WIDTH   = 16,
    parameter int WM_IN_W = 8,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int WM_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               shift_active,
    input  logic               tx_push,
    input  logic [WIDTH-1:0]   tx_push_data,
    input  logic               tx_pop,
    output logic [WIDTH-1:0]   tx_pop_data,
    input  logic               rx_push,
    input  logic [WIDTH-1:0]   rx_push_data,
    input  logic               rx_pop,
    output logic [WIDTH-1:0]   rx_pop_data,
    input  logic               tx_wm_wr,
    input  logic               rx_wm_wr,
    input  logic [WM_IN_W-1:0] wm_wdata,
    output logic [WM_W-1:0]    tx_wm,
    output logic [WM_W-1:0]    rx_wm,
    input  logic               mask_wr,
    input  logic [4:0]         mask_wdata,
    input  logic               clr_wr,
    input  logic [3:0]         clr_wdata,
    output logic [LVL_W-1:0]   tx_level,
    output logic [LVL_W-1:0]   rx_level,
    output logic [4:0]         status,
    output logic [4:0]         irq_raw,
    output logic [4:0]         irq_masked,
    output logic               irq
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic        flush;
    logic        tx_ovf_ev, tx_udf_unused, rx_ovf_ev, rx_udf_ev;
    fsi_status_t st;
    fsi_irq_t    raw;

    assign flush = !enable;

    spi_fsi_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(flush),
        .push(tx_push), .push_data(tx_push_data),
        .pop(tx_pop), .pop_data(tx_pop_data),
        .level(tx_level), .ovf_ev(tx_ovf_ev), .udf_ev(tx_udf_unused)
    );

    spi_fsi_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(flush),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_pop), .pop_data(rx_pop_data),
        .level(rx_level), .ovf_ev(rx_ovf_ev), .udf_ev(rx_udf_ev)
    );

    spi_fsi_wm #(.DEPTH(DEPTH), .WM_IN_W(WM_IN_W)) u_tx_wm (
        .clk(clk), .rst(rst), .enable(enable),
        .wr(tx_wm_wr), .wdata(wm_wdata), .wm(tx_wm)
    );

    spi_fsi_wm #(.DEPTH(DEPTH), .WM_IN_W(WM_IN_W)) u_rx_wm (
        .clk(clk), .rst(rst), .enable(enable),
        .wr(rx_wm_wr), .wdata(wm_wdata), .wm(rx_wm)
    );

    spi_fsi_irq #(.DEPTH(DEPTH)) u_irq (
        .clk(clk), .rst(rst),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_wm(tx_wm), .rx_wm(rx_wm),
        .tx_ovf_ev(tx_ovf_ev), .rx_ovf_ev(rx_ovf_ev), .rx_udf_ev(rx_udf_ev),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .raw(raw), .masked(irq_masked), .irq_o(irq)
    );

    always_comb begin
        st.busy     = enable && (shift_active || tx_level != '0);
        st.tx_full  = (tx_level == FULL_LVL);
        st.tx_empty = (tx_level == '0);
        st.rx_empty = (rx_level == '0);
        st.rx_full  = (rx_level == FULL_LVL);
    end

    assign status  = st;
    assign irq_raw = raw;

    a_r3_full_empty_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(status[1] && status[2]) && !(status[3] && status[4]));

    a_r9_disabled_not_busy: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !status[0]);

    a_r11_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (tx_level == '0 && rx_level == '0 && irq_raw[3:1] == '0 && !irq));

endmodule

// File: tb/spi_fifo_irq_unit_tb.sv
module spi_fifo_irq_unit_tb;

    localparam int DEPTH = 32;
    localparam int WIDTH = 16;
    localparam int WM_IN_W = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int WM_W = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0, shift_active = 1'b0;
    logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [WIDTH-1:0] tx_push_data = '0, rx_push_data = '0;
    logic [WIDTH-1:0] tx_pop_data, rx_pop_data;
    logic tx_wm_wr = 1'b0, rx_wm_wr = 1'b0;
    logic [WM_IN_W-1:0] wm_wdata = '0;
    logic [WM_W-1:0] tx_wm, rx_wm;
    logic mask_wr = 1'b0, clr_wr = 1'b0;
    logic [4:0] mask_wdata = '0;
    logic [3:0] clr_wdata = '0;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic [4:0] status, irq_raw, irq_masked;
    logic irq;

    always #10 clk = ~clk;

    spi_fifo_irq_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH), .WM_IN_W(WM_IN_W)) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .shift_active(shift_active),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
        .tx_wm_wr(tx_wm_wr), .rx_wm_wr(rx_wm_wr), .wm_wdata(wm_wdata), .tx_wm(tx_wm), .rx_wm(rx_wm),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .tx_level(tx_level), .rx_level(rx_level), .status(status),
        .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq)
    );

    // behavioural reference model
    int txq[$];
    int rxq[$];
    int m_txwm, m_rxwm, m_mask;
    bit m_tovf, m_rovf, m_rudf;
    int n_checks = 0, n_fail = 0;
    int cyc_cnt = 0;

    always @(posedge clk) begin
        bit tfull, tempty, rfull, rempty;
        cyc_cnt++;
        if (rst) begin
            txq.delete(); rxq.delete();
            m_txwm = 0; m_rxwm = 0; m_mask = 0;
            m_tovf = 0; m_rovf = 0; m_rudf = 0;
        end else begin
            tfull  = (txq.size() == DEPTH);
            tempty = (txq.size() == 0);
            rfull  = (rxq.size() == DEPTH);
            rempty = (rxq.size() == 0);
            if (clr_wr) begin
                if (clr_wdata[0] || clr_wdata[1]) m_rudf = 0;
                if (clr_wdata[0] || clr_wdata[2]) m_rovf = 0;
                if (clr_wdata[0] || clr_wdata[3]) m_tovf = 0;
            end
            if (!enable) begin
                txq.delete(); rxq.delete();
                if (tx_wm_wr) m_txwm = int'(wm_wdata) % DEPTH;
                if (rx_wm_wr) m_rxwm = int'(wm_wdata) % DEPTH;
            end else begin
                if (tx_pop && !tempty) void'(txq.pop_front());
                if (tx_push) begin
                    if (tfull) m_tovf = 1; else txq.push_back(int'(tx_push_data));
                end
                if (rx_pop) begin
                    if (rempty) m_rudf = 1; else void'(rxq.pop_front());
                end
                if (rx_push) begin
                    if (rfull) m_rovf = 1; else rxq.push_back(int'(rx_push_data));
                end
            end
            if (mask_wr) m_mask = int'(mask_wdata);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_raw();
        int r;
        r = 0;
        if (txq.size() <= m_txwm) r |= 1;
        if (m_tovf) r |= 2;
        if (m_rudf) r |= 4;
        if (m_rovf) r |= 8;
        if (rxq.size() > m_rxwm) r |= 16;
        return r;
    endfunction

    task automatic compare_all();
        int es, er;
        es = 0;
        if (enable && (shift_active || txq.size() != 0)) es |= 1;
        if (txq.size() == DEPTH) es |= 2;
        if (txq.size() == 0) es |= 4;
        if (rxq.size() == 0) es |= 8;
        if (rxq.size() == DEPTH) es |= 16;
        er = exp_raw();
        chk("R1", "tx_level", int'(tx_level), txq.size());
        chk("R1", "rx_level", int'(rx_level), rxq.size());
        if (txq.size() > 0) chk("R1", "tx_pop_data", int'(tx_pop_data), txq[0]);
        if (rxq.size() > 0) chk("R1", "rx_pop_data", int'(rx_pop_data), rxq[0]);
        chk("R3", "status", int'(status), es);
        chk("R4", "raw tx watermark", int'(irq_raw[0]), er & 1);
        chk("R5", "raw rx watermark", int'(irq_raw[4]), (er >> 4) & 1);
        chk("R6", "raw error bits", int'(irq_raw[3:1]), (er >> 1) & 7);
        chk("R8", "masked", int'(irq_masked), er & m_mask);
        chk("R8", "irq line", int'(irq), int'((er & m_mask) != 0));
        chk("R10", "tx_wm", int'(tx_wm), m_txwm);
        chk("R10", "rx_wm", int'(rx_wm), m_rxwm);
    endtask

    task automatic quiet();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        tx_wm_wr = 0; rx_wm_wr = 0; mask_wr = 0; clr_wr = 0;
    endtask

    // one clock: inputs already driven, then sample at the following falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (!rst) compare_all();
        quiet();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cyc_cnt > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        cyc();
        // R11 reset state
        chk("R11", "tx_level", int'(tx_level), 0);
        chk("R11", "rx_level", int'(rx_level), 0);
        chk("R11", "wm pair", int'({tx_wm, rx_wm}), 0);
        chk("R11", "raw", int'(irq_raw), 5'b00001);
        chk("R11", "irq", int'(irq), 0);

        // R10 watermark truncation while disabled
        mask_wr = 1; mask_wdata = 5'h1F;
        tx_wm_wr = 1; wm_wdata = 8'h23; cyc();
        chk("R10", "tx_wm truncated", int'(tx_wm), 3);
        rx_wm_wr = 1; wm_wdata = 8'h04; cyc();
        enable = 1; cyc();
        tx_wm_wr = 1; rx_wm_wr = 1; wm_wdata = 8'h07; cyc();
        chk("R10", "tx_wm locked", int'(tx_wm), 3);
        chk("R10", "rx_wm locked", int'(rx_wm), 4);

        // R4 transmit watermark edge
        for (int i = 0; i < 4; i++) begin
            tx_push = 1; tx_push_data = WIDTH'(16'hA000 + i); cyc();
        end
        chk("R4", "tx wm at level 4", int'(irq_raw[0]), 0);
        tx_pop = 1; cyc();
        chk("R4", "tx wm at level 3", int'(irq_raw[0]), 1);
        chk("R1", "head after pop", int'(tx_pop_data), 16'hA001);

        // R5 receive watermark edge
        for (int i = 0; i < 5; i++) begin
            rx_push = 1; rx_push_data = WIDTH'(16'h5000 + i); cyc();
            chk("R5", "rx wm edge", int'(irq_raw[4]), int'(i == 4));
        end

        // R1 simultaneous push and pop
        rx_push = 1; rx_pop = 1; rx_push_data = 16'h5EEE; cyc();
        chk("R1", "pair keeps level", int'(rx_level), 5);

        // R2 / R6 transmit overflow
        for (int i = 0; i < DEPTH; i++) begin
            tx_push = 1; tx_push_data = WIDTH'(16'hB000 + i); cyc();
        end
        chk("R2", "tx full level", int'(tx_level), DEPTH);
        chk("R6", "tx overflow flag", int'(irq_raw[1]), 1);
        tx_push = 1; tx_push_data = 16'hDEAD; cyc();
        chk("R2", "tx level held", int'(tx_level), DEPTH);

        // R2 / R6 receive underflow
        for (int i = 0; i < 8; i++) begin rx_pop = 1; cyc(); end
        chk("R2", "rx empty level", int'(rx_level), 0);
        chk("R6", "rx underflow flag", int'(irq_raw[2]), 1);
        for (int i = 0; i < DEPTH + 2; i++) begin
            rx_push = 1; rx_push_data = WIDTH'(16'hC000 + i); cyc();
        end
        chk("R6", "rx overflow flag", int'(irq_raw[3]), 1);
        cyc();
        chk("R6", "flags sticky", int'(irq_raw[3:1]), 3'b111);

        // R7 single clears and set-wins
        clr_wr = 1; clr_wdata = 4'b0010; cyc();
        chk("R7", "udf cleared only", int'(irq_raw[3:1]), 3'b101);
        clr_wr = 1; clr_wdata = 4'b1000; tx_push = 1; tx_push_data = 16'h1111; cyc();
        chk("R7", "set wins over clear", int'(irq_raw[1]), 1);
        clr_wr = 1; clr_wdata = 4'b0100; cyc();
        chk("R7", "ovf cleared", int'(irq_raw[3:1]), 3'b001);
        clr_wr = 1; clr_wdata = 4'b0001; cyc();
        chk("R7", "clear all", int'(irq_raw[3:1]), 0);

        // R8 mask behaviour
        mask_wr = 1; mask_wdata = 5'h10; cyc();
        chk("R8", "only rx wm masked in", int'(irq_masked), 5'h10);
        mask_wr = 1; mask_wdata = 5'h00; cyc();
        chk("R8", "zero mask silent", int'(irq), 0);

        // R9 disable flushes, strobes ignored
        enable = 0; cyc();
        chk("R9", "tx flushed", int'(tx_level), 0);
        chk("R9", "rx flushed", int'(rx_level), 0);
        tx_push = 1; rx_pop = 1; rx_push = 1; tx_pop = 1; cyc();
        chk("R9", "levels stay zero", int'({tx_level, rx_level}), 0);
        chk("R9", "no error flag", int'(irq_raw[3:1]), 0);
        enable = 1; cyc();

        // mixed random traffic against the model
        mask_wr = 1; mask_wdata = 5'h1F; cyc();
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(99) == 0) enable = ~enable;
            shift_active = 1'($urandom_range(1));
            tx_push = ($urandom_range(99) < 50);
            tx_pop  = ($urandom_range(99) < 45);
            rx_push = ($urandom_range(99) < 45);
            rx_pop  = ($urandom_range(99) < 50);
            tx_push_data = WIDTH'($urandom);
            rx_push_data = WIDTH'($urandom);
            tx_wm_wr = ($urandom_range(99) < 3);
            rx_wm_wr = ($urandom_range(99) < 3);
            wm_wdata = WM_IN_W'($urandom);
            mask_wr = ($urandom_range(99) < 4);
            mask_wdata = 5'($urandom);
            clr_wr = ($urandom_range(99) < 6);
            clr_wdata = 4'($urandom);
            cyc();
        end
        finish_run();
    end

endmodule